// File: doc/BRIEF.md
# TDM Time-Slot Routing Engine

The engine steers every time slot of a TDM frame to one of five internal serial channels, or leaves it idle. Transmit and receive each have their own route table and their own frame timing, so a slot can feed one channel on the transmit side and a different channel on the receive side. Each table entry covers a run of consecutive slots and names a single channel code. The walker for each direction steps through its table as slot boundaries arrive from the serial front end. It produces a channel select, a one-hot channel enable that is held for the whole slot, and a one-hot strobe in the first cycle of each slot.

Software writes entries through a single write port. Writes always land in a shadow table. The shadow is copied into the active table whenever the engine is disabled, and at every frame start of that direction. A frame in progress therefore always finishes on the routing it started with.

Top module: `tdm_slot_router`

## Requirements
- R1: An entry is written as `wr_cnt_m1_i` (6 bits, slot count minus one, so each entry spans 1 to 64 slots), `wr_code_i` (3 bits) and `wr_last_i` (final valid entry). `wr_rx_i` picks the table: 0 for transmit, 1 for receive. `wr_idx_i` picks the entry.
- R2: A frame pulse with `en_i` high restarts that direction at entry 0, slot 0. The outputs for slot 0 appear in the cycle after the pulse.
- R3: Entries are consumed in index order. An entry with count minus one equal to N keeps its code for N+1 slots, and each slot pulse advances by exactly one slot.
- R4: Codes 1 to 5 set `*_sel_o` to the code and set bit code-1 of `*_en_o`. Codes 0, 6 and 7 give `*_sel_o` = 0 and no enable bit.
- R5: After the entry flagged last, or after entry 63 when no entry carries the flag, every remaining slot is unused until the next frame pulse.
- R6: `*_stb_o` equals `*_en_o` in the first cycle of a slot, meaning the cycle after a frame pulse or a slot pulse. In all other cycles it is zero.
- R7: A write made while enabled takes effect at the next frame pulse of its direction. A write made in the same cycle as that pulse waits for the following one.
- R8: The transmit and receive tables, walkers and pulses act independently of each other.
- R9: While `en_i` is low, every select, enable and strobe output is zero and frame and slot pulses are ignored. Writes reach the active table at once.
- R10: When a frame pulse and a slot pulse arrive in the same cycle, the frame pulse wins.
- R11: After reset, and until the first enabled frame pulse, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Engine enable |
| wr_en_i | input | 1 | Table entry write strobe |
| wr_rx_i | input | 1 | Table select: 0 transmit, 1 receive |
| wr_idx_i | input | 6 | Entry index |
| wr_cnt_m1_i | input | 6 | Slot count minus one |
| wr_code_i | input | 3 | Channel code |
| wr_last_i | input | 1 | Entry is the last valid one |
| tx_frame_i | input | 1 | Transmit frame start pulse |
| tx_slot_i | input | 1 | Transmit slot boundary pulse |
| rx_frame_i | input | 1 | Receive frame start pulse |
| rx_slot_i | input | 1 | Receive slot boundary pulse |
| tx_sel_o | output | 3 | Transmit source channel code, 0 when unused |
| tx_en_o | output | 5 | Transmit one-hot channel enable |
| tx_stb_o | output | 5 | Transmit slot-start strobe |
| rx_sel_o | output | 3 | Receive destination channel code, 0 when unused |
| rx_en_o | output | 5 | Receive one-hot channel enable |
| rx_stb_o | output | 5 | Receive slot-start strobe |

## Verification
The assertions assume that the front end delivers frame and slot pulses as single-cycle events. They also assume that the active table changes only when the walker restarts or is idle, so the slot position inside an entry never exceeds that entry's count. The stimulus keeps within this by routing every write through the port, so writes reach the shadow and never touch the active copy mid-frame. Random tables use the full 3-bit code range, and pulses for the two directions are drawn separately, with idle gaps between them of random length.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
  localparam int CNT_W  = 6;
  localparam int CODE_W = 3;
  localparam int CH_NUM = 5;

  typedef struct packed {
    logic              last;
    logic [CODE_W-1:0] code;
    logic [CNT_W-1:0]  cnt_m1;
  } entry_t;
endpackage

// File: rtl/tsr_table.sv
module tsr_table import tsr_pkg::*; #(
  parameter int DEPTH = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             commit_i,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  entry_t           wr_ent_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output entry_t           rd_ent_o
);
  entry_t ac_arr [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    entry_t sh_q, ac_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sh_q <= '0;
        ac_q <= '0;
      end else begin
        // commit samples the shadow before a same-cycle write lands
        if (commit_i) ac_q <= sh_q;
        if (wr_en_i && wr_idx_i == IDX_W'(g)) sh_q <= wr_ent_i;
      end
    end
    assign ac_arr[g] = ac_q;
  end

  assign rd_ent_o = ac_arr[rd_idx_i];
endmodule

// File: rtl/tsr_walker.sv
module tsr_walker import tsr_pkg::*; #(
  parameter int DEPTH = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              frame_i,
  input  logic              tick_i,
  input  entry_t            cur_ent_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic [CODE_W-1:0] code_o,
  output logic              new_o
);
  logic             run_q, done_q, new_q;
  logic [IDX_W-1:0] idx_q;
  logic [CNT_W-1:0] pos_q;
  logic             end_of_ent, tbl_end;

  assign end_of_ent = (pos_q == cur_ent_i.cnt_m1);
  assign tbl_end    = cur_ent_i.last || (idx_q == IDX_W'(DEPTH - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0; done_q <= 1'b0; new_q <= 1'b0;
      idx_q <= '0;   pos_q  <= '0;
    end else if (!en_i) begin
      run_q <= 1'b0; done_q <= 1'b0; new_q <= 1'b0;
      idx_q <= '0;   pos_q  <= '0;
    end else if (frame_i) begin
      run_q <= 1'b1; done_q <= 1'b0; new_q <= 1'b1;
      idx_q <= '0;   pos_q  <= '0;
    end else if (tick_i && run_q) begin
      new_q <= 1'b1;
      if (!done_q) begin
        if (end_of_ent) begin
          if (tbl_end) done_q <= 1'b1;
          else begin
            idx_q <= idx_q + 1'b1;
            pos_q <= '0;
          end
        end else begin
          pos_q <= pos_q + 1'b1;
        end
      end
    end else begin
      new_q <= 1'b0;
    end
  end

  assign idx_o  = idx_q;
  assign code_o = (run_q && !done_q) ? cur_ent_i.code : '0;
  assign new_o  = new_q && run_q;

  a_r2_frame_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && frame_i |=> run_q && new_q && idx_q == '0 && pos_q == '0);
  a_r3_pos_in_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && !done_q |-> pos_q <= cur_ent_i.cnt_m1);
  a_r3_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !frame_i && tick_i && run_q && !done_q && !end_of_ent
    |=> pos_q == $past(pos_q) + 1'b1 && $stable(idx_q));
  a_r5_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !frame_i && done_q |=> done_q && code_o == '0);
  a_r9_idle_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !run_q && code_o == '0);
endmodule

// File: rtl/tsr_decode.sv
module tsr_decode import tsr_pkg::*; (
  input  logic [CODE_W-1:0] code_i,
  input  logic              new_i,
  output logic [CODE_W-1:0] sel_o,
  output logic [CH_NUM-1:0] en_o,
  output logic [CH_NUM-1:0] stb_o
);
  logic valid;
  assign valid = (code_i != '0) && (int'(code_i) <= CH_NUM);
  assign sel_o = valid ? code_i : '0;

  for (genvar c = 0; c < CH_NUM; c++) begin : g_ch
    assign en_o[c]  = (sel_o == CODE_W'(c + 1));
    assign stb_o[c] = en_o[c] && new_i;
  end
endmodule

// File: rtl/tdm_slot_router.sv
module tdm_slot_router import tsr_pkg::*; #(
  parameter int DEPTH = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              wr_en_i,
  input  logic              wr_rx_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [CNT_W-1:0]  wr_cnt_m1_i,
  input  logic [CODE_W-1:0] wr_code_i,
  input  logic              wr_last_i,
  input  logic              tx_frame_i,
  input  logic              tx_slot_i,
  input  logic              rx_frame_i,
  input  logic              rx_slot_i,
  output logic [CODE_W-1:0] tx_sel_o,
  output logic [CH_NUM-1:0] tx_en_o,
  output logic [CH_NUM-1:0] tx_stb_o,
  output logic [CODE_W-1:0] rx_sel_o,
  output logic [CH_NUM-1:0] rx_en_o,
  output logic [CH_NUM-1:0] rx_stb_o
);
  localparam int DIRS = 2;

  entry_t            wr_ent;
  logic [DIRS-1:0]   frame_v, tick_v;
  logic [CODE_W-1:0] sel_v [DIRS];
  logic [CH_NUM-1:0] en_v  [DIRS];
  logic [CH_NUM-1:0] stb_v [DIRS];

  assign wr_ent  = '{last: wr_last_i, code: wr_code_i, cnt_m1: wr_cnt_m1_i};
  assign frame_v = {rx_frame_i, tx_frame_i};
  assign tick_v  = {rx_slot_i, tx_slot_i};

  for (genvar d = 0; d < DIRS; d++) begin : g_dir
    entry_t            cur_ent;
    logic [IDX_W-1:0]  rd_idx;
    logic [CODE_W-1:0] code;
    logic              slot_new;

    tsr_table #(.DEPTH(DEPTH)) u_table (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .commit_i (!en_i || frame_v[d]),
      .wr_en_i  (wr_en_i && (wr_rx_i == d[0])),
      .wr_idx_i (wr_idx_i),
      .wr_ent_i (wr_ent),
      .rd_idx_i (rd_idx),
      .rd_ent_o (cur_ent)
    );

    tsr_walker #(.DEPTH(DEPTH)) u_walker (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_i      (en_i),
      .frame_i   (frame_v[d]),
      .tick_i    (tick_v[d]),
      .cur_ent_i (cur_ent),
      .idx_o     (rd_idx),
      .code_o    (code),
      .new_o     (slot_new)
    );

    tsr_decode u_decode (
      .code_i (code),
      .new_i  (slot_new),
      .sel_o  (sel_v[d]),
      .en_o   (en_v[d]),
      .stb_o  (stb_v[d])
    );
  end

  assign tx_sel_o = sel_v[0];
  assign tx_en_o  = en_v[0];
  assign tx_stb_o = stb_v[0];
  assign rx_sel_o = sel_v[1];
  assign rx_en_o  = en_v[1];
  assign rx_stb_o = stb_v[1];

  a_r4_tx_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(tx_en_o) && ((tx_sel_o == '0) == (tx_en_o == '0)));
  a_r4_rx_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rx_en_o) && ((rx_sel_o == '0) == (rx_en_o == '0)));
  a_r6_stb_within_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((tx_stb_o & ~tx_en_o) == '0) && ((rx_stb_o & ~rx_en_o) == '0));
  a_r6_stb_after_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_frame_i && !tx_slot_i |=> tx_stb_o == '0);
  a_r9_outputs_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> tx_en_o == '0 && rx_en_o == '0 && tx_sel_o == '0 && rx_sel_o == '0);
endmodule

// File: tb/tdm_slot_router_tb.sv
module tdm_slot_router_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic       en = 0, wr_en = 0, wr_rx = 0, wr_last = 0;
  logic [5:0] wr_idx = 0, wr_cnt = 0;
  logic [2:0] wr_code = 0;
  logic       txf = 0, txs = 0, rxf = 0, rxs = 0;
  logic [2:0] tx_sel, rx_sel;
  logic [4:0] tx_en, tx_stb, rx_en, rx_stb;

  tdm_slot_router u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en),
    .wr_en_i(wr_en), .wr_rx_i(wr_rx), .wr_idx_i(wr_idx),
    .wr_cnt_m1_i(wr_cnt), .wr_code_i(wr_code), .wr_last_i(wr_last),
    .tx_frame_i(txf), .tx_slot_i(txs), .rx_frame_i(rxf), .rx_slot_i(rxs),
    .tx_sel_o(tx_sel), .tx_en_o(tx_en), .tx_stb_o(tx_stb),
    .rx_sel_o(rx_sel), .rx_en_o(rx_en), .rx_stb_o(rx_stb)
  );

  int errors = 0, checks = 0;
  bit finished = 0;
  string tag = "R11";

  int sh_cnt [2][64], sh_code [2][64], sh_last [2][64];
  int ac_cnt [2][64], ac_code [2][64], ac_last [2][64];
  int m_slot [2], m_run [2], m_new [2];

  function automatic int code_at(int d, int slot);
    int s = slot;
    for (int i = 0; i < 64; i++) begin
      if (s <= ac_cnt[d][i]) return (ac_code[d][i] >= 1 && ac_code[d][i] <= 5) ? ac_code[d][i] : 0;
      s -= ac_cnt[d][i] + 1;
      if (ac_last[d][i] != 0) return 0;
    end
    return 0;
  endfunction

  function automatic int exp_sel(int d);
    return m_run[d] != 0 ? code_at(d, m_slot[d]) : 0;
  endfunction

  function automatic int exp_en(int d);
    int c = exp_sel(d);
    return c == 0 ? 0 : (1 << (c - 1));
  endfunction

  task automatic model_edge();
    bit fr [2];
    bit tk [2];
    fr[0] = txf; fr[1] = rxf; tk[0] = txs; tk[1] = rxs;
    for (int d = 0; d < 2; d++) begin
      if (!en || fr[d]) begin
        for (int i = 0; i < 64; i++) begin
          ac_cnt[d][i] = sh_cnt[d][i]; ac_code[d][i] = sh_code[d][i]; ac_last[d][i] = sh_last[d][i];
        end
      end
      if (wr_en && int'(wr_rx) == d) begin
        sh_cnt[d][wr_idx] = wr_cnt; sh_code[d][wr_idx] = wr_code; sh_last[d][wr_idx] = wr_last;
      end
      if (!en) begin m_run[d] = 0; m_new[d] = 0; end
      else if (fr[d]) begin m_run[d] = 1; m_slot[d] = 0; m_new[d] = 1; end
      else if (tk[d] && m_run[d] != 0) begin m_slot[d]++; m_new[d] = 1; end
      else m_new[d] = 0;
    end
  endtask

  task automatic chk(string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s got=%0d exp=%0d at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("tx_sel", int'(tx_sel), exp_sel(0));
    chk("tx_en",  int'(tx_en),  exp_en(0));
    chk("tx_stb", int'(tx_stb), m_new[0] != 0 ? exp_en(0) : 0);
    chk("rx_sel", int'(rx_sel), exp_sel(1));
    chk("rx_en",  int'(rx_en),  exp_en(1));
    chk("rx_stb", int'(rx_stb), m_new[1] != 0 ? exp_en(1) : 0);
  endtask

  task automatic step();
    @(posedge clk);
    if (rst_n) model_edge();
    @(negedge clk);
    check_all();
    wr_en = 0; txf = 0; txs = 0; rxf = 0; rxs = 0;
  endtask

  task automatic wr(int d, int idx, int cnt, int code, int last);
    wr_en = 1; wr_rx = d[0]; wr_idx = idx[5:0]; wr_cnt = cnt[5:0];
    wr_code = code[2:0]; wr_last = last[0];
    step();
  endtask

  task automatic tick_n(int d, int n);
    for (int k = 0; k < n; k++) begin
      if (d == 0) txs = 1; else rxs = 1;
      step();
      step();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED_1234);
    for (int d = 0; d < 2; d++) begin
      m_slot[d] = 0; m_run[d] = 0; m_new[d] = 0;
      for (int i = 0; i < 64; i++) begin
        sh_cnt[d][i] = 0; sh_code[d][i] = 0; sh_last[d][i] = 0;
        ac_cnt[d][i] = 0; ac_code[d][i] = 0; ac_last[d][i] = 0;
      end
    end
    @(negedge clk);
    tag = "R11 reset"; check_all();
    rst_n = 1;
    step(); step();

    // R9: disabled engine ignores pulses; example table R1 R3
    tag = "R9 disabled";
    wr(0, 0, 1, 0, 0); wr(0, 1, 23, 3, 0); wr(0, 2, 0, 0, 0); wr(0, 3, 4, 2, 1);
    wr(1, 0, 0, 7, 0); wr(1, 1, 1, 6, 0); wr(1, 2, 2, 5, 0); wr(1, 3, 0, 1, 1);
    txf = 1; rxf = 1; step(); txs = 1; step();

    // R2 R3 R4 R6: walk full example frame, reserved codes on rx
    en = 1; step();
    tag = "R2 R3 R4 R6 walk";
    txf = 1; rxf = 1; step();
    tick_n(0, 34);
    tag = "R4 reserved codes";
    tick_n(1, 8);

    // R5: last flag, then entry 63 end when no flag
    tag = "R5 end of table";
    wr(0, 0, 2, 4, 1); txf = 1; step(); tick_n(0, 6);
    for (int i = 0; i < 64; i++) wr(1, i, 0, (i % 5) + 1, 0);
    rxf = 1; step(); tick_n(1, 67);

    // R7: write mid-frame deferred; write on frame edge deferred further
    tag = "R7 shadow";
    wr(0, 0, 63, 1, 1); step(); tick_n(0, 2);
    txf = 1; step();
    tick_n(0, 3);
    wr_en = 1; wr_rx = 0; wr_idx = 0; wr_cnt = 0; wr_code = 3; wr_last = 1;
    txf = 1; step(); tick_n(0, 2);
    txf = 1; step(); tick_n(0, 2);

    // R10: frame beats slot pulse in the same cycle
    tag = "R10 frame priority";
    wr(0, 0, 0, 2, 0); wr(0, 1, 0, 5, 1); txf = 1; step(); tick_n(0, 1);
    txf = 1; txs = 1; step(); step();

    // R9: dropping enable clears outputs mid-frame
    tag = "R9 disable mid-frame";
    en = 0; step(); txs = 1; step(); en = 1; step(); step();

    // R8 R1: random tables and independent pulse streams
    tag = "R8 random";
    for (int it = 0; it < 12000; it++) begin
      int r = int'($urandom_range(0, 99));
      if (r < 6) begin
        wr_en = 1; wr_rx = $urandom_range(0, 1); wr_idx = $urandom_range(0, 7);
        wr_cnt = (($urandom_range(0, 3) == 0) ? $urandom_range(0, 63) : $urandom_range(0, 3));
        wr_code = $urandom_range(0, 7); wr_last = ($urandom_range(0, 5) == 0);
      end
      if ($urandom_range(0, 60) == 0) txf = 1;
      if ($urandom_range(0, 60) == 0) rxf = 1;
      if ($urandom_range(0, 2) == 0) txs = 1;
      if ($urandom_range(0, 2) == 0) rxs = 1;
      if ($urandom_range(0, 999) == 0) en = ~en;
      step();
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule